// File: doc/BRIEF.md
# Split Issue Queue with Thread Steering

This block is the instruction holding stage of an out-of-order core whose back end is cut into two mirror-image halves. Each half keeps its own pool of waiting instructions (32 by default) and feeds only its own private set of execution port groups: load/store, integer, load-only and vector. One instruction is offered per cycle on the dispatch side, tagged with a hardware thread number, an execution group code and a result tag. Steering logic decides which half takes it.

The choice of half depends on how many threads the core is running. With a single thread, that thread may spread its work over both halves to get all the issue bandwidth. With two, four or eight threads, every thread is tied to one half, picked by the lowest bit of its thread number. Two threads therefore see two fully separate back ends, and neither can fill or block the other's storage. Each half marks entries ready from the ready bit given at dispatch or from a broadcast wakeup tag. In every cycle it issues, for each port group, the ready entry that was allocated earliest. A flush input on each half removes every entry of one thread from that half in one cycle.

Top module: `split_issue_queue`

## Requirements
- R1: After reset both halves are empty, `half_count` reads 0 for both halves, no `iss_valid` bit is set and `disp_stall` is low.
- R2: With `mode` = 0 (one thread), accepted instructions alternate between halves, half 0 first. After each accepted instruction the preferred half becomes the half not just used, and `disp_tid` is ignored.
- R3: With `mode` = 0, when the preferred half is full the instruction goes to the other half. `disp_stall` is raised only when `disp_valid` is high and both halves are full.
- R4: With `mode` = 1, 2 or 3 (two, four or eight threads), the instruction goes to half `disp_tid[0]`. It stalls when that half is full, even if the other half has room.
- R5: Each half holds at most `ENTRIES` instructions. `half_count` slice h (bits h*6 upward for the defaults) gives the number held in half h.
- R6: Each half issues at most one instruction per group per cycle. `iss_valid`, `iss_tag` and `iss_tid` index h*GROUPS+g carry half h, group g, where g is the `disp_group` code (0 load/store, 1 integer, 2 load, 3 vector). Among the ready entries of that group, the one allocated first is chosen.
- R7: An entry is ready if `disp_ready` was high at dispatch, or once a `wake_valid` with a matching `wake_tag` has been seen while it was held. A wakeup takes effect from the next cycle and does not touch an instruction dispatched in the same cycle.
- R8: `flush_valid[h]` removes every entry of thread `flush_tid[h*3 +: 3]` from half h at the clock edge. Those entries are not issued in that cycle, and the other half is untouched.
- R9: An entry leaves the queue at the edge that ends the cycle in which it is issued.
- R10: Backpressure uses the occupancy at the start of the cycle. Entries issued or flushed in a cycle free their space only from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | Thread mode: 0 one, 1 two, 2 four, 3 eight threads |
| disp_valid | input | 1 | Dispatch offer this cycle |
| disp_tid | input | 3 | Thread number of the offered instruction |
| disp_group | input | 2 | Execution group code of the instruction |
| disp_tag | input | 8 | Result tag of the instruction |
| disp_ready | input | 1 | Operands already available at dispatch |
| disp_stall | output | 1 | Offer not taken this cycle |
| wake_valid | input | 1 | Broadcast wakeup present |
| wake_tag | input | 8 | Tag being woken |
| flush_valid | input | 2 | Per-half flush request |
| flush_tid | input | 6 | Per-half thread to flush, 3 bits per half |
| iss_valid | output | 8 | Issue strobe per half and group |
| iss_tag | output | 64 | Tag of each issued instruction, 8 bits per slot |
| iss_tid | output | 24 | Thread of each issued instruction, 3 bits per slot |
| half_count | output | 12 | Occupancy per half, 6 bits per half |

## Verification
The properties assume that `mode` only changes while both halves are empty, that `disp_group` stays below GROUPS, and that `disp_tid` stays within the thread count of the current mode. They also assume the flush thread number is one that can live in that half. The stimulus keeps to this by changing mode only after a flush sweep over every thread number, and by drawing thread numbers from the range the active mode allows. Because the wakeup tags come from a narrow range, several entries often share a tag. This makes many entries ready in the same cycle and puts the oldest-first choice to work.

// File: rtl/siq_pkg.sv
package siq_pkg;

  typedef enum logic [1:0] {
    MODE_ONE   = 2'd0,
    MODE_TWO   = 2'd1,
    MODE_FOUR  = 2'd2,
    MODE_EIGHT = 2'd3
  } thr_mode_e;

  // Returns {accept, half}. 'single' selects the one-thread policy.
  function automatic logic [1:0] steer_pick(input logic       single,
                                            input logic       pref,
                                            input logic       tid_lsb,
                                            input logic [1:0] full);
    logic h;
    logic ok;
    if (single) begin
      if (!full[pref]) begin
        h  = pref;
        ok = 1'b1;
      end else begin
        h  = ~pref;
        ok = !full[~pref];
      end
    end else begin
      h  = tid_lsb;
      ok = !full[tid_lsb];
    end
    return {ok, h};
  endfunction

endpackage

// File: rtl/siq_steer.sv
module siq_steer
  import siq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode,
  input  logic       disp_valid,
  input  logic       tid_lsb,
  input  logic [1:0] half_full,
  output logic       accept,
  output logic       half_sel
);

  logic       pref_q;
  logic       single;
  logic [1:0] pick;

  assign single   = (thr_mode_e'(mode) == MODE_ONE);
  assign pick     = steer_pick(single, pref_q, tid_lsb, half_full);
  assign accept   = disp_valid & pick[1];
  assign half_sel = pick[0];

  always_ff @(posedge clk) begin
    if (!rst_n)                pref_q <= 1'b0;
    else if (single && accept) pref_q <= ~half_sel;
  end

endmodule

// File: rtl/siq_half.sv
module siq_half #(
  parameter int ENTRIES = 32,
  parameter int GROUPS  = 4,
  parameter int TID_W   = 3,
  parameter int TAG_W   = 8,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int GRP_W  = (GROUPS > 1) ? $clog2(GROUPS) : 1,
  localparam int CNT_W  = $clog2(ENTRIES + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      alloc_en,
  input  logic [TID_W-1:0]          alloc_tid,
  input  logic [GRP_W-1:0]          alloc_grp,
  input  logic [TAG_W-1:0]          alloc_tag,
  input  logic                      alloc_rdy,
  input  logic                      wake_valid,
  input  logic [TAG_W-1:0]          wake_tag,
  input  logic                      flush_valid,
  input  logic [TID_W-1:0]          flush_tid,
  output logic [GROUPS-1:0]         iss_valid,
  output logic [GROUPS*TAG_W-1:0]   iss_tag,
  output logic [GROUPS*TID_W-1:0]   iss_tid,
  output logic [CNT_W-1:0]          count,
  output logic                      full
);

  logic [ENTRIES-1:0] vld_q, rdy_q;
  logic [TID_W-1:0]   tid_q   [ENTRIES];
  logic [GRP_W-1:0]   grp_q   [ENTRIES];
  logic [TAG_W-1:0]   tag_q   [ENTRIES];
  // older_q[i][j] set: entry j was allocated before entry i
  logic [ENTRIES-1:0] older_q [ENTRIES];

  logic [ENTRIES-1:0] flush_hit, wake_hit, issued;
  logic [ENTRIES-1:0] grant   [GROUPS];
  logic [IDX_W-1:0]   slot;

  function automatic logic [IDX_W-1:0] lowest_free(input logic [ENTRIES-1:0] v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) if (!v[i]) r = IDX_W'(i);
    return r;
  endfunction

  function automatic logic [IDX_W-1:0] oh_index(input logic [ENTRIES-1:0] oh);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = 0; i < ENTRIES; i++) if (oh[i]) r = IDX_W'(i);
    return r;
  endfunction

  function automatic logic [CNT_W-1:0] pop(input logic [ENTRIES-1:0] v);
    logic [CNT_W-1:0] c;
    c = '0;
    for (int i = 0; i < ENTRIES; i++) c = c + {{(CNT_W-1){1'b0}}, v[i]};
    return c;
  endfunction

  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      flush_hit[i] = vld_q[i] & flush_valid & (tid_q[i] == flush_tid);
      wake_hit[i]  = vld_q[i] & wake_valid  & (tag_q[i] == wake_tag);
    end
  end

  assign slot  = lowest_free(vld_q);
  assign count = pop(vld_q);
  assign full  = &vld_q;

  for (genvar g = 0; g < GROUPS; g++) begin : g_port
    logic [ENTRIES-1:0] req;
    logic [IDX_W-1:0]   win_idx;
    always_comb begin
      for (int i = 0; i < ENTRIES; i++)
        req[i] = vld_q[i] & rdy_q[i] & ~flush_hit[i] & (grp_q[i] == GRP_W'(g));
      for (int i = 0; i < ENTRIES; i++)
        grant[g][i] = req[i] & ~|(req & older_q[i]);
    end
    assign win_idx                    = oh_index(grant[g]);
    assign iss_valid[g]               = |grant[g];
    assign iss_tag[g*TAG_W +: TAG_W]  = tag_q[win_idx];
    assign iss_tid[g*TID_W +: TID_W]  = tid_q[win_idx];
  end

  always_comb begin
    issued = '0;
    for (int g = 0; g < GROUPS; g++) issued = issued | grant[g];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= '0;
      rdy_q <= '0;
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (issued[i] | flush_hit[i]) vld_q[i] <= 1'b0;
        if (wake_hit[i])              rdy_q[i] <= 1'b1;
      end
      if (alloc_en) begin
        vld_q[slot] <= 1'b1;
        rdy_q[slot] <= alloc_rdy;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (alloc_en) begin
      tid_q[slot]   <= alloc_tid;
      grp_q[slot]   <= alloc_grp;
      tag_q[slot]   <= alloc_tag;
      older_q[slot] <= vld_q;
      for (int j = 0; j < ENTRIES; j++) older_q[j][slot] <= 1'b0;
    end
  end

endmodule

// File: rtl/split_issue_queue.sv
module split_issue_queue #(
  parameter int ENTRIES = 32,
  parameter int GROUPS  = 4,
  parameter int TID_W   = 3,
  parameter int TAG_W   = 8,
  localparam int GRP_W  = (GROUPS > 1) ? $clog2(GROUPS) : 1,
  localparam int CNT_W  = $clog2(ENTRIES + 1)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [1:0]                  mode,
  input  logic                        disp_valid,
  input  logic [TID_W-1:0]            disp_tid,
  input  logic [GRP_W-1:0]            disp_group,
  input  logic [TAG_W-1:0]            disp_tag,
  input  logic                        disp_ready,
  output logic                        disp_stall,
  input  logic                        wake_valid,
  input  logic [TAG_W-1:0]            wake_tag,
  input  logic [1:0]                  flush_valid,
  input  logic [2*TID_W-1:0]          flush_tid,
  output logic [2*GROUPS-1:0]         iss_valid,
  output logic [2*GROUPS*TAG_W-1:0]   iss_tag,
  output logic [2*GROUPS*TID_W-1:0]   iss_tid,
  output logic [2*CNT_W-1:0]          half_count
);

  logic [1:0] half_full;
  logic [1:0] alloc_en;
  logic       accept;
  logic       steer_half;

  siq_steer u_steer (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode       (mode),
    .disp_valid (disp_valid),
    .tid_lsb    (disp_tid[0]),
    .half_full  (half_full),
    .accept     (accept),
    .half_sel   (steer_half)
  );

  assign disp_stall = disp_valid & ~accept;
  assign alloc_en   = {accept & steer_half, accept & ~steer_half};

  for (genvar h = 0; h < 2; h++) begin : g_half
    siq_half #(
      .ENTRIES (ENTRIES),
      .GROUPS  (GROUPS),
      .TID_W   (TID_W),
      .TAG_W   (TAG_W)
    ) u_half (
      .clk         (clk),
      .rst_n       (rst_n),
      .alloc_en    (alloc_en[h]),
      .alloc_tid   (disp_tid),
      .alloc_grp   (disp_group),
      .alloc_tag   (disp_tag),
      .alloc_rdy   (disp_ready),
      .wake_valid  (wake_valid),
      .wake_tag    (wake_tag),
      .flush_valid (flush_valid[h]),
      .flush_tid   (flush_tid[h*TID_W +: TID_W]),
      .iss_valid   (iss_valid[h*GROUPS +: GROUPS]),
      .iss_tag     (iss_tag[h*GROUPS*TAG_W +: GROUPS*TAG_W]),
      .iss_tid     (iss_tid[h*GROUPS*TID_W +: GROUPS*TID_W]),
      .count       (half_count[h*CNT_W +: CNT_W]),
      .full        (half_full[h])
    );
  end

endmodule

// File: rtl/siq_checker.sv
module siq_checker #(
  parameter int ENTRIES = 32,
  parameter int GROUPS  = 4,
  parameter int TID_W   = 3,
  localparam int CNT_W  = $clog2(ENTRIES + 1)
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [1:0]                 mode,
  input logic                       disp_valid,
  input logic                       tid_lsb,
  input logic                       disp_stall,
  input logic [1:0]                 flush_valid,
  input logic [2*TID_W-1:0]         flush_tid,
  input logic [2*GROUPS-1:0]        iss_valid,
  input logic [2*GROUPS*TID_W-1:0]  iss_tid,
  input logic [2*CNT_W-1:0]         half_count,
  input logic [1:0]                 alloc_en,
  input logic [1:0]                 half_full,
  input logic                       steer_half
);

  logic taken;
  logic prev_ok, prev_half;

  assign taken = disp_valid & ~disp_stall;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_ok   <= 1'b0;
      prev_half <= 1'b0;
    end else if (mode == 2'd0 && taken) begin
      prev_ok   <= 1'b1;
      prev_half <= steer_half;
    end
  end

  assert_alternate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd0 && taken && half_full == 2'b00 && prev_ok) |-> (steer_half != prev_half));

  assert_one_thread_stall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd0 && disp_stall) |-> (half_full == 2'b11));

  assert_bound_half_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != 2'd0 && taken) |-> (alloc_en[tid_lsb] && !alloc_en[~tid_lsb]));

  assert_bound_stall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != 2'd0 && disp_valid && !half_full[tid_lsb]) |-> !disp_stall);

  for (genvar h = 0; h < 2; h++) begin : g_h
    assert_count_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
      half_count[h*CNT_W +: CNT_W] <= CNT_W'(ENTRIES));

    assert_no_alloc_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
      alloc_en[h] |-> !half_full[h]);

    assert_step_limit_R10: assert property (@(posedge clk) disable iff (!rst_n)
      half_count[h*CNT_W +: CNT_W] <= $past(half_count[h*CNT_W +: CNT_W]) + CNT_W'(1));

    for (genvar g = 0; g < GROUPS; g++) begin : g_g
      assert_flush_blocks_issue_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid[h*GROUPS+g] && flush_valid[h]) |->
          (iss_tid[(h*GROUPS+g)*TID_W +: TID_W] != flush_tid[h*TID_W +: TID_W]));
    end
  end

endmodule

bind split_issue_queue siq_checker #(
  .ENTRIES (ENTRIES),
  .GROUPS  (GROUPS),
  .TID_W   (TID_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .mode        (mode),
  .disp_valid  (disp_valid),
  .tid_lsb     (disp_tid[0]),
  .disp_stall  (disp_stall),
  .flush_valid (flush_valid),
  .flush_tid   (flush_tid),
  .iss_valid   (iss_valid),
  .iss_tid     (iss_tid),
  .half_count  (half_count),
  .alloc_en    (alloc_en),
  .half_full   (half_full),
  .steer_half  (steer_half)
);

// File: tb/split_issue_queue_bench.sv
module split_issue_queue_bench;

  localparam int E  = 32;
  localparam int G  = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  mode;
  logic        disp_valid;
  logic [2:0]  disp_tid;
  logic [1:0]  disp_group;
  logic [7:0]  disp_tag;
  logic        disp_ready;
  logic        disp_stall;
  logic        wake_valid;
  logic [7:0]  wake_tag;
  logic [1:0]  flush_valid;
  logic [5:0]  flush_tid;
  logic [7:0]  iss_valid;
  logic [63:0] iss_tag;
  logic [23:0] iss_tid;
  logic [11:0] half_count;

  int n_chk = 0;
  int n_fail = 0;

  // Reference model: per half, entries kept in allocation order.
  int mn   [2];
  int mtag [2][E];
  int mtid [2][E];
  int mgrp [2][E];
  bit mrdy [2][E];
  int mtog;

  always #5 clk = ~clk;

  split_issue_queue u_split_issue_queue (
    .clk, .rst_n, .mode, .disp_valid, .disp_tid, .disp_group, .disp_tag,
    .disp_ready, .disp_stall, .wake_valid, .wake_tag, .flush_valid,
    .flush_tid, .iss_valid, .iss_tag, .iss_tid, .half_count
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic quiet();
    disp_valid = 0; disp_tid = 0; disp_group = 0; disp_tag = 0; disp_ready = 0;
    wake_valid = 0; wake_tag = 0; flush_valid = 0; flush_tid = 0;
  endtask

  task automatic offer(input int tid, input int grp, input int tag, input bit rdy);
    quiet();
    disp_valid = 1; disp_tid = 3'(tid); disp_group = 2'(grp);
    disp_tag = 8'(tag); disp_ready = rdy;
  endtask

  // Compare the current cycle against the model, advance the model, move to next negedge.
  task automatic tick();
    int  ftid [2];
    bit  acc;
    int  hsel;
    bit  eiv [2][G];
    int  eix [2][G];
    int  k2;
    bit  drop;
    #1;
    ftid[0] = int'(flush_tid[2:0]);
    ftid[1] = int'(flush_tid[5:3]);
    acc = 0; hsel = 0;
    if (disp_valid) begin
      if (mode == 2'd0) begin
        if (mn[mtog] < E) begin acc = 1; hsel = mtog; end
        else if (mn[1-mtog] < E) begin acc = 1; hsel = 1 - mtog; end
      end else begin
        hsel = int'(disp_tid[0]);
        acc  = (mn[hsel] < E);
      end
    end
    chk(mode == 2'd0 ? "R3" : "R4", int'(disp_stall), int'(disp_valid && !acc));
    for (int h = 0; h < 2; h++) begin
      chk("R5", int'(half_count[h*6 +: 6]), mn[h]);
      for (int g = 0; g < G; g++) begin
        eiv[h][g] = 0; eix[h][g] = -1;
        for (int k = 0; k < mn[h]; k++)
          if (!eiv[h][g] && mgrp[h][k] == g && mrdy[h][k] &&
              !(flush_valid[h] && mtid[h][k] == ftid[h])) begin
            eiv[h][g] = 1; eix[h][g] = k;
          end
        chk("R6", int'(iss_valid[h*G+g]), int'(eiv[h][g]));
        if (eiv[h][g]) begin
          chk("R6", int'(iss_tag[(h*G+g)*8 +: 8]), mtag[h][eix[h][g]]);
          chk("R6", int'(iss_tid[(h*G+g)*3 +: 3]), mtid[h][eix[h][g]]);
        end
      end
    end
    for (int h = 0; h < 2; h++) begin
      k2 = 0;
      for (int k = 0; k < mn[h]; k++) begin
        drop = (eix[h][mgrp[h][k]] == k) ||
               (flush_valid[h] && mtid[h][k] == ftid[h]);
        if (!drop) begin
          mtag[h][k2] = mtag[h][k];
          mtid[h][k2] = mtid[h][k];
          mgrp[h][k2] = mgrp[h][k];
          mrdy[h][k2] = mrdy[h][k] || (wake_valid && int'(wake_tag) == mtag[h][k]);
          k2++;
        end
      end
      mn[h] = k2;
    end
    if (acc) begin
      mtag[hsel][mn[hsel]] = int'(disp_tag);
      mtid[hsel][mn[hsel]] = int'(disp_tid);
      mgrp[hsel][mn[hsel]] = int'(disp_group);
      mrdy[hsel][mn[hsel]] = disp_ready;
      mn[hsel]++;
      if (mode == 2'd0) mtog = 1 - hsel;
    end
    @(negedge clk);
  endtask

  task automatic flush_all();
    for (int t = 0; t < 8; t++) begin
      quiet(); flush_valid = 2'b11; flush_tid = {3'(t), 3'(t)};
      tick();
    end
    quiet(); #1;
    chk("R8", int'(half_count), 0);
    tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    mn[0] = 0; mn[1] = 0; mtog = 0;
    rst_n = 0; mode = 0; quiet();
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk("R1", int'(half_count), 0);
    chk("R1", int'(iss_valid), 0);
    chk("R1", int'(disp_stall), 0);
    tick();

    // One-thread mode: alternation, then fill both halves.
    mode = 2'd0;
    offer(5, 1, 1, 0); tick();
    offer(6, 1, 2, 0); tick();
    quiet(); #1;
    chk("R2", int'(half_count[5:0]), 1);
    chk("R2", int'(half_count[11:6]), 1);
    tick();
    for (int t = 3; t <= 68; t++) begin
      offer(0, t % 4, t, 0);
      if (t >= 65) begin #1; chk("R3", int'(disp_stall), 1); end
      tick();
    end
    quiet(); wake_valid = 1; wake_tag = 8'd5; #1;
    chk("R7", int'(iss_valid), 0);
    tick();
    quiet(); #1;
    chk("R7", int'(iss_valid[1]), 1);
    chk("R7", int'(iss_tag[15:8]), 5);
    chk("R10", int'(half_count[5:0]), 32);
    tick();
    quiet(); #1;
    chk("R9", int'(half_count[5:0]), 31);
    tick();
    flush_all();

    // Four-thread mode: two same-tag entries in half 1, oldest first.
    mode = 2'd2;
    offer(3, 2, 50, 0); tick();
    offer(1, 2, 50, 0); tick();
    quiet(); wake_valid = 1; wake_tag = 8'd50; tick();
    quiet(); #1;
    chk("R6", int'(iss_valid[6]), 1);
    chk("R6", int'(iss_tid[20:18]), 3);
    tick();
    quiet(); #1;
    chk("R6", int'(iss_tid[20:18]), 1);
    tick();
    flush_all();

    // Two-thread mode: bound half full, other half free.
    mode = 2'd1;
    for (int i = 0; i < 32; i++) begin offer(0, 0, 100 + i, 0); tick(); end
    offer(0, 0, 140, 0); #1; chk("R4", int'(disp_stall), 1); tick();
    offer(1, 0, 200, 0); #1; chk("R4", int'(disp_stall), 0); tick();
    quiet(); wake_valid = 1; wake_tag = 8'd100; tick();
    offer(0, 0, 141, 0); #1;
    chk("R6", int'(iss_valid[0]), 1);
    chk("R10", int'(disp_stall), 1);
    tick();
    offer(0, 0, 142, 0); #1; chk("R10", int'(disp_stall), 0); tick();
    quiet(); wake_valid = 1; wake_tag = 8'd101; tick();
    quiet(); flush_valid = 2'b01; flush_tid = 6'd0; #1;
    chk("R8", int'(iss_valid[0]), 0);
    tick();
    quiet(); #1;
    chk("R8", int'(half_count[5:0]), 0);
    chk("R8", int'(half_count[11:6]), 1);
    tick();
    flush_all();

    // Randomised traffic in each mode.
    for (int m = 0; m < 4; m++) begin
      mode = 2'(m);
      for (int c = 0; c < 700; c++) begin
        quiet();
        if ($urandom_range(0, 9) < 7)
          offer($urandom_range(0, (1 << m) - 1), $urandom_range(0, 3),
                $urandom_range(0, 15), $urandom_range(0, 9) < 4);
        if ($urandom_range(0, 1) == 1) begin
          wake_valid = 1; wake_tag = 8'($urandom_range(0, 15));
        end
        for (int h = 0; h < 2; h++)
          if ($urandom_range(0, 99) < 3) begin
            flush_valid[h] = 1'b1;
            flush_tid[h*3 +: 3] = 3'($urandom_range(0, (1 << m) - 1));
          end
        tick();
      end
      flush_all();
    end

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule